// File: doc/BRIEF.md
# Board Control Interrupt Hub

This block is a bank of board-control registers behind a simple synchronous bus port, paired with an interrupt hub. The hub watches sixteen level-sensitive external sources and forwards their activity to one upstream interrupt line. The register bank covers LED data and control, a switch word, three miscellaneous control words, a miscellaneous status word, and two card-slot words. All of these are plain storage. Two further registers drive the hub: an enable mask and a set/clear word.

The bus port decodes a byte offset inside a 1 MB window. A write takes effect at the clock edge where select and write enable are both high. Read data is combinational, and it is valid while select is high and write enable is low.

Source inputs are registered every clock. A source whose sample differs from the previous sample has changed. Every change is copied into an internal level vector. A change on an enabled source also does two things:
- it overwrites the set/clear word with a one-hot code naming that source;
- it drives the upstream line to that source's new level.

A write to the enable mask folds the set/clear word into the level vector with an XOR. Each level bit that flips as a result is driven onto the matching per-source output.

Top module: `brd_irq_hub`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, and `src_lvl` and `irq_up` are zero.
- R2: The plain registers read back the last value written to them. Their byte offsets are 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4, and they are 32 bits wide.
- R3: A read from an offset outside the map returns zero. A write to such an offset changes no register. Read data is zero while `bus_sel` is low.
- R4: The enable mask (offset 0xC0) and the set/clear word (offset 0xD0) store the written value ANDed with 0x000FEEFF. As a result, sources 8 and 12 can never be enabled.
- R5: Suppose source i changes level and mask bit i is set. At the edge where the change is sampled, the set/clear word becomes 1<<i and `irq_up` takes the new level of source i.
- R6: A change on a source whose mask bit is clear leaves both the set/clear word and `irq_up` unchanged.
- R7: A write to the enable mask first forms a new level vector: the old level vector XOR the low 16 bits of the set/clear word. Every bit of the new vector that differs from the old one is copied into `src_lvl`, and the new vector then replaces the old one. `src_lvl` changes at no other time.
- R8: If several enabled sources change in the same cycle, the highest-numbered one supplies both the one-hot code and the level for `irq_up`.
- R9: A bus write to the set/clear word has priority over a source event in the same cycle. The event still updates `irq_up`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable (1 = write, 0 = read) |
| bus_addr | input | 20 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_in | input | 16 | Level-sensitive interrupt sources |
| src_lvl | output | 16 | Per-source level outputs |
| irq_up | output | 1 | Upstream interrupt line |

## Verification
Two of the block's functions can land on the same clock edge:
- a bus write to the set/clear word, and an enabled source event that wants to overwrite it;
- several enabled sources changing together.

The bench provokes the first by raising an enabled source on the same cycle as a write to the set/clear word. It then judges the result in two places: the stored word must equal the masked write data, and `irq_up` must still follow the source. For the second case, it raises two enabled sources at once and expects the code and the level of the higher one.

// File: rtl/brd_pkg.sv
// Package: shared constants for the board control interrupt hub.
// Assumes a 20-bit byte offset and 32-bit data words.
package brd_pkg;
    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 32;
    localparam int NPLAIN  = 10;
    localparam logic [DATA_W-1:0] HUB_WMASK = 32'h000F_EEFF;
    localparam logic [ADDR_W-1:0] OFS_ENMASK = 20'h000C0;
    localparam logic [ADDR_W-1:0] OFS_SETCLR = 20'h000D0;

    // Byte offset of plain storage register number i
    function automatic logic [ADDR_W-1:0] plain_ofs(input int i);
        case (i)
            0:       plain_ofs = 20'h00010;
            1:       plain_ofs = 20'h00014;
            2:       plain_ofs = 20'h00040;
            3:       plain_ofs = 20'h00060;
            4:       plain_ofs = 20'h00080;
            5:       plain_ofs = 20'h00084;
            6:       plain_ofs = 20'h00088;
            7:       plain_ofs = 20'h00090;
            8:       plain_ofs = 20'h000E0;
            default: plain_ofs = 20'h000E4;
        endcase
    endfunction
endpackage

// File: rtl/brd_pick.sv
// Module: brd_pick
// Purpose: from a request vector, picks the highest-numbered set bit and
// gives its index, its one-hot code and a hit flag.
// Assumes N >= 2. Purely combinational.
module brd_pick #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    // Scan upward so that the last set bit, which is the highest, wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
        onehot = hit ? (N'(1) << idx) : '0;
    end

    // Assertion R8: any hit yields exactly one code bit
    always_comb begin
        if (hit) begin
            p_onehot_code_r8: assert ($countones(onehot) == 1);
        end
    end
endmodule

// File: rtl/brd_regfile.sv
// Module: brd_regfile
// Purpose: plain 32-bit storage registers at fixed byte offsets, with a
// combinational read mux.
// Assumes the caller drives rd_en only for reads. Offsets outside the table
// read as zero and ignore writes.
module brd_regfile
    import brd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NPLAIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          hit
);
    logic [DW-1:0] store [NR];
    logic [NR-1:0] sel_v;

    // Address decode: one select line per register
    always_comb begin
        for (int i = 0; i < NR; i++) begin
            sel_v[i] = (addr == AW'(plain_ofs(i)));
        end
    end

    assign hit = |sel_v;

    generate
        for (genvar g = 0; g < NR; g++) begin : g_reg
            // Storage register g: cleared on reset, loaded on a matching write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store[g] <= '0;
                end else if (wr_en && sel_v[g]) begin
                    store[g] <= wdata;
                end
            end
        end
    endgenerate

    // Read mux: OR of the selected entries, zero when nothing matches
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NR; i++) begin
                if (sel_v[i]) rdata = rdata | store[i];
            end
        end
    end

    // Assertion R3: an unmapped read returns zero
    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |-> (rdata == '0));

    // Assertion R2: a write is visible on the next cycle's read at that offset
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) ##1 (rd_en && addr == $past(addr)) |-> (rdata == $past(wdata)));
endmodule

// File: rtl/brd_irq_core.sv
// Module: brd_irq_core
// Purpose: source sampling, level vector, enable mask, set/clear word,
// per-source outputs and the upstream line.
// Assumes NSRC <= DW. When a mask write and a source event share an edge,
// the mask write folds the set/clear word into the event-updated level vector.
module brd_irq_core
    import brd_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int NSRC = 16,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] src_in,
    output logic [DW-1:0]   rdata,
    output logic            hit,
    output logic [NSRC-1:0] src_lvl,
    output logic            irq_up
);
    logic [NSRC-1:0] src_q, lv_q, lvl_q;
    logic [DW-1:0]   mask_q, sc_q;
    logic            irq_q;
    logic [NSRC-1:0] chg, en_chg, lv_evt, lv_new, sc_low, code;
    logic [IW-1:0]   pidx;
    logic            phit;
    logic            sel_mask, sel_sc, wr_mask, wr_sc;

    assign sel_mask = (addr == AW'(OFS_ENMASK));
    assign sel_sc   = (addr == AW'(OFS_SETCLR));
    assign wr_mask  = wr_en && sel_mask;
    assign wr_sc    = wr_en && sel_sc;
    assign hit      = sel_mask || sel_sc;

    // Change detection against the previous sample
    assign chg    = src_in ^ src_q;
    assign en_chg = chg & mask_q[NSRC-1:0];
    assign sc_low = sc_q[NSRC-1:0];

    // Level vector after this cycle's source events, then after the XOR fold
    assign lv_evt = (lv_q & ~chg) | (src_in & chg);
    assign lv_new = lv_evt ^ sc_low;

    brd_pick #(.N(NSRC)) u_pick (
        .req    (en_chg),
        .hit    (phit),
        .idx    (pidx),
        .onehot (code)
    );

    // Source sample register
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_in;
    end

    // Enable mask register: stores the write value through the fixed pattern
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata & HUB_WMASK;
    end

    // Set/clear word: a bus write wins over an event code
    always_ff @(posedge clk) begin
        if (!rst_n)       sc_q <= '0;
        else if (wr_sc)   sc_q <= wdata & HUB_WMASK;
        else if (phit)    sc_q <= DW'(code);
    end

    // Upstream line follows the picked enabled source
    always_ff @(posedge clk) begin
        if (!rst_n)    irq_q <= 1'b0;
        else if (phit) irq_q <= src_in[pidx];
    end

    // Level vector: tracks events; a mask write replaces it with the fold
    always_ff @(posedge clk) begin
        if (!rst_n)       lv_q <= '0;
        else if (wr_mask) lv_q <= lv_new;
        else              lv_q <= lv_evt;
    end

    // Per-source outputs: only bits flipped by the fold are driven
    always_ff @(posedge clk) begin
        if (!rst_n)       lvl_q <= '0;
        else if (wr_mask) lvl_q <= (lvl_q & ~(lv_new ^ lv_evt)) | (lv_new & (lv_new ^ lv_evt));
    end

    // Read mux for the two hub registers
    always_comb begin
        rdata = '0;
        if (rd_en && sel_mask) rdata = mask_q;
        if (rd_en && sel_sc)   rdata = sc_q;
    end

    assign src_lvl = lvl_q;
    assign irq_up  = irq_q;

    // Assertion R4: a mask write stores the masked value
    p_mask_pattern_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == ($past(wdata) & HUB_WMASK)));

    // Assertion R5: an event without a bus write leaves a one-hot code
    p_event_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phit && !wr_sc) |=> ($countones(sc_q) == 1));

    // Assertion R6: no enabled change and no write leaves the word and the line alone
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_chg == '0 && !wr_sc) |=> ($stable(sc_q) && $stable(irq_q)));

    // Assertion R7: the per-source outputs move only on a mask write
    p_lvl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(lvl_q));

    // Assertion R9: a bus write to the set/clear word wins
    p_bus_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sc |=> (sc_q == ($past(wdata) & HUB_WMASK)));
endmodule

// File: rtl/brd_irq_hub.sv
// Module: brd_irq_hub (top)
// Purpose: board-control register bank plus the interrupt hub, joined on
// one bus port.
// Assumes one access per cycle. Read data is combinational and zero unless
// bus_sel is high and bus_we is low.
module brd_irq_hub
    import brd_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_in,
    output logic [NSRC-1:0] src_lvl,
    output logic            irq_up
);
    logic          wr_en, rd_en;
    logic [DW-1:0] rd_plain, rd_hub;
    logic          hit_plain, hit_hub;

    assign wr_en = bus_sel && bus_we;
    assign rd_en = bus_sel && !bus_we;

    brd_regfile #(.AW(AW), .DW(DW), .NR(NPLAIN)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (rd_plain),
        .hit   (hit_plain)
    );

    brd_irq_core #(.AW(AW), .DW(DW), .NSRC(NSRC)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .src_in  (src_in),
        .rdata   (rd_hub),
        .hit     (hit_hub),
        .src_lvl (src_lvl),
        .irq_up  (irq_up)
    );

    // Read data: the two sources never decode the same offset
    assign bus_rdata = rd_plain | rd_hub;

    // Assertion R3: read data is zero while no read is in progress
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (bus_rdata == '0));

    // Assertion R3: no offset decodes in both sub-blocks
    p_decode_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_plain && hit_hub));
endmodule

// File: tb/brd_irq_hub_test.sv
// Directed bench for brd_irq_hub. Inputs are driven on the falling edge and
// outputs are sampled 1 ns after the rising edge.
module brd_irq_hub_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [19:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] src_in;
    logic [15:0] src_lvl;
    logic        irq_up;

    int total = 0;
    int bad   = 0;

    localparam logic [19:0] PLAIN [10] = '{20'h10, 20'h14, 20'h40, 20'h60,
        20'h80, 20'h84, 20'h88, 20'h90, 20'hE0, 20'hE4};

    always #2 clk = ~clk;

    brd_irq_hub uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .src_lvl   (src_lvl),
        .irq_up    (irq_up)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0; src_in = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic src_set(input logic [15:0] v);
        @(negedge clk);
        src_in = v;
        @(posedge clk);
        #1;
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        for (int i = 0; i < 10; i++) begin
            rd(PLAIN[i], d);
            chk("R1", "plain reg after reset", d, 32'h0);
        end
        rd(20'hC0, d); chk("R1", "mask after reset", d, 32'h0);
        rd(20'hD0, d); chk("R1", "setclr after reset", d, 32'h0);
        chk("R1", "src_lvl after reset", {16'h0, src_lvl}, 32'h0);
        chk("R1", "irq_up after reset", {31'h0, irq_up}, 32'h0);
    endtask

    // R2 and R3: plain storage, unmapped offsets, idle read data
    task automatic t_storage();
        logic [31:0] d;
        do_reset();
        for (int i = 0; i < 10; i++) wr(PLAIN[i], 32'hA5000000 + 32'(i * 32'h1111));
        wr(20'h44, 32'hDEADBEEF);
        wr(20'h91, 32'h12345678);
        for (int i = 0; i < 10; i++) begin
            rd(PLAIN[i], d);
            chk("R2", "plain readback", d, 32'hA5000000 + 32'(i * 32'h1111));
        end
        rd(20'h44, d);  chk("R3", "unmapped read 0x44", d, 32'h0);
        rd(20'h91, d);  chk("R3", "unmapped read 0x91", d, 32'h0);
        rd(20'hC0, d);  chk("R3", "mask untouched by unmapped write", d, 32'h0);
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = 20'h10;
        #1 chk("R3", "rdata with sel low", bus_rdata, 32'h0);
    endtask

    // R4: write pattern on mask and set/clear
    task automatic t_pattern();
        logic [31:0] d;
        do_reset();
        wr(20'hC0, 32'hFFFFFFFF);
        rd(20'hC0, d); chk("R4", "mask masked", d, 32'h000FEEFF);
        wr(20'hD0, 32'hFFFFFFFF);
        rd(20'hD0, d); chk("R4", "setclr masked", d, 32'h000FEEFF);
        wr(20'hD0, 32'h00000001);
        src_set(16'h0100);
        rd(20'hD0, d); chk("R4", "source 8 never enabled", d, 32'h1);
        chk("R4", "irq_up after source 8", {31'h0, irq_up}, 32'h0);
    endtask

    // R5 and R6: enabled and disabled sources
    task automatic t_events();
        logic [31:0] d;
        do_reset();
        wr(20'hC0, 32'h00000010);
        src_set(16'h0010);
        chk("R5", "irq_up on rise", {31'h0, irq_up}, 32'h1);
        rd(20'hD0, d); chk("R5", "code on rise", d, 32'h10);
        wr(20'hD0, 32'h0);
        src_set(16'h0014);
        chk("R6", "irq_up on masked rise", {31'h0, irq_up}, 32'h1);
        rd(20'hD0, d); chk("R6", "setclr on masked rise", d, 32'h0);
        src_set(16'h0010);
        chk("R6", "irq_up on masked fall", {31'h0, irq_up}, 32'h1);
        src_set(16'h0000);
        chk("R5", "irq_up on fall", {31'h0, irq_up}, 32'h0);
        rd(20'hD0, d); chk("R5", "code on fall", d, 32'h10);
    endtask

    // R7: XOR fold on a mask write
    task automatic t_fold();
        logic [31:0] d;
        do_reset();
        src_set(16'h0005);
        wr(20'hD0, 32'h00000003);
        chk("R7", "src_lvl before fold", {16'h0, src_lvl}, 32'h0);
        wr(20'hC0, 32'h0);
        @(posedge clk); #1;
        chk("R7", "src_lvl after first fold", {16'h0, src_lvl}, 32'h0002);
        wr(20'hC0, 32'h0);
        @(posedge clk); #1;
        chk("R7", "src_lvl after second fold", {16'h0, src_lvl}, 32'h0001);
        rd(20'hD0, d); chk("R7", "setclr kept", d, 32'h3);
    endtask

    // R8: several enabled sources in the same cycle
    task automatic t_multi();
        logic [31:0] d;
        do_reset();
        wr(20'hC0, 32'h000000A0);
        src_set(16'h00A0);
        rd(20'hD0, d); chk("R8", "highest code", d, 32'h80);
        chk("R8", "irq_up from highest", {31'h0, irq_up}, 32'h1);
        src_set(16'h0088);
        rd(20'hD0, d); chk("R8", "code from fallen source 5", d, 32'h20);
        chk("R8", "irq_up from source 5", {31'h0, irq_up}, 32'h0);
    endtask

    // R9: a bus write and a source event on the same edge
    task automatic t_collide();
        logic [31:0] d;
        do_reset();
        wr(20'hC0, 32'h00000010);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 20'hD0; bus_wdata = 32'h00000F00;
        src_in = 16'h0010;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(20'hD0, d); chk("R9", "bus write wins", d, 32'h00000E00);
        chk("R9", "irq_up still follows", {31'h0, irq_up}, 32'h1);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0; src_in = '0;
        t_reset();
        t_storage();
        t_pattern();
        t_events();
        t_fold();
        t_multi();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule